// File: doc/BRIEF.md
# PWM Action Qualifier with Continuous Software Force

This block sits between a PWM time-base counter and the output pins. It takes the counter's event strobes (counter at zero, counter at period, counter matching compare A while counting up, counter matching compare B while counting up) and a prescaler tick, and produces two PWM levels, `pwm_a` and `pwm_b`. Each output has its own action word. For every event, the word selects one of four actions: leave the level alone, drive it low, drive it high or toggle it. Events take effect only on cycles where the prescaler tick is high.

Software can hold either output at a fixed level through a continuous force word. The force word is double-buffered. A register write lands in a shadow copy, and a reload-select field decides when the shadow copy moves into the active copy: at the zero event, at the period event, at either of the two, or at the next tick. While the active force code for an output asks for low or high, that level replaces every event action for the output.

The force loader is a two-state machine. `FRC_SYNCED` means the shadow and active copies agree. `FRC_PENDING` means a new shadow value is waiting. The transitions are:
- `SYNCED -> PENDING` on a write to the force register.
- `PENDING -> SYNCED` on a tick that meets the reload condition, provided no force write arrives in the same cycle.
- `PENDING -> PENDING` otherwise.

Each output holds a two-state level machine, `LVL_LOW` and `LVL_HIGH`. It moves on a tick according to the force code or the winning event action. Otherwise it holds.

Top module: `pwm_aq`

## Requirements
- R1: After reset both outputs are low, and every register reads as zero. With all action words zero, ticks with any events leave both outputs low.
- R2: The register address decides the target. Address 0 is the action word for A, address 1 is the action word for B, address 2 is the force setup word and address 3 is the force word. Each action word has four 2-bit fields: zero event in bits [1:0], period event in [3:2], compare-A-up in [5:4] and compare-B-up in [9:8]. The action codes are 00 none, 01 drive low, 10 drive high and 11 toggle.
- R3: An output changes only on a cycle where `tick` is high. Events presented while `tick` is low have no effect, and the output changes at the clock edge that samples the tick.
- R4: When several events arrive on one tick, only one action applies. It is the first action with a non-zero code, taken in the order compare-B, compare-A, period, zero. An event whose code is 00 does not hide a lower-priority one.
- R5: The force word holds the code for A in bits [1:0] and the code for B in [3:2]. Code 01 forces low and 10 forces high; codes 00 and 11 force nothing. On each tick, an active force of low or high sets the level of its output no matter which events are present.
- R6: Reload select is bits [7:6] of the setup word. With code 00, a written force value becomes active on the first tick that carries the zero event, and not before.
- R7: With reload code 01, a written force value becomes active on the first tick that carries the period event.
- R8: With reload code 10, a written force value becomes active on the first tick that carries either the zero event or the period event.
- R9: With reload code 11, a written force value becomes active on the next tick, whatever its events. A force write in the same cycle as a reload tick goes to the shadow and waits for the next reload point.
- R10: Action word 0x01A on A and 0x10A on B give normal polarity: high at zero and at period, low at the channel's own compare-up. Words 0x025 and 0x205 give the inverted waveform.
- R11: The two outputs are independent. A's action word and force code never affect B, and B's never affect A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaler tick; events and force reload act only when high |
| ev_zero | input | 1 | Counter-at-zero event |
| ev_period | input | 1 | Counter-at-period event |
| ev_cmpa | input | 1 | Compare A match while counting up |
| ev_cmpb | input | 1 | Compare B match while counting up |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 act A, 1 act B, 2 setup, 3 force) |
| wr_data | input | 10 | Register write data |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |

## Verification
Every result of this block appears one clock edge after its cause. This holds for:
- a tick-driven level change;
- a force reload;
- a register write, which affects output levels only from the next tick onward.

The bench drives inputs on the falling edge and lets the rising edge capture them. The driver pushes the expected levels just after that rising edge, and the monitor compares them on the following falling edge. As a result, each expectation is compared exactly one edge after the stimulus it belongs to. Reload tests place ticks without the qualifying event between the write and the reload point, so an early load shows up as a mismatch.

// File: rtl/aq_pkg.sv
package aq_pkg;
    localparam int NUM_CH  = 2;
    localparam int ADDR_W  = 2;
    localparam int DATA_W  = 10;
    localparam int CODE_W  = 2;
    localparam int FRC_W   = CODE_W * NUM_CH;

    localparam logic [ADDR_W-1:0] ADR_ACT_A = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_ACT_B = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_SETUP = 2'd2;
    localparam logic [ADDR_W-1:0] ADR_FORCE = 2'd3;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_LOW    = 2'b01,
        ACT_HIGH   = 2'b10,
        ACT_TOGGLE = 2'b11
    } act_e;

    typedef enum logic [1:0] {
        RLD_ZERO   = 2'b00,
        RLD_PERIOD = 2'b01,
        RLD_EITHER = 2'b10,
        RLD_NOW    = 2'b11
    } rld_e;

    typedef enum logic {
        FRC_SYNCED  = 1'b0,
        FRC_PENDING = 1'b1
    } frc_state_e;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_e;

    typedef struct packed {
        act_e on_cmpb;
        act_e on_cmpa;
        act_e on_period;
        act_e on_zero;
    } act_word_t;

    typedef struct packed {
        logic zero;
        logic period;
        logic cmpa;
        logic cmpb;
    } evt_t;
endpackage

// File: rtl/aq_regs.sv
module aq_regs
    import aq_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    output act_word_t                 act_q [NUM_CH],
    output rld_e                      reload_sel,
    output logic                      frc_wr,
    output logic [FRC_W-1:0]          frc_wdata
);
    act_word_t act_r [NUM_CH];
    rld_e      rsel_r;

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_act
            localparam logic [ADDR_W-1:0] MY_ADR = ADDR_W'(c);
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    act_r[c] <= '{ACT_NONE, ACT_NONE, ACT_NONE, ACT_NONE};
                end else if (wr_en && wr_addr == MY_ADR) begin
                    act_r[c] <= '{act_e'(wr_data[9:8]), act_e'(wr_data[5:4]),
                                  act_e'(wr_data[3:2]), act_e'(wr_data[1:0])};
                end
            end
            assign act_q[c] = act_r[c];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsel_r <= RLD_ZERO;
        end else if (wr_en && wr_addr == ADR_SETUP) begin
            rsel_r <= rld_e'(wr_data[7:6]);
        end
    end

    assign reload_sel = rsel_r;
    assign frc_wr     = wr_en && (wr_addr == ADR_FORCE);
    assign frc_wdata  = wr_data[FRC_W-1:0];
endmodule

// File: rtl/aq_force_ctl.sv
module aq_force_ctl
    import aq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  evt_t               ev,
    input  rld_e               reload_sel,
    input  logic               frc_wr,
    input  logic [FRC_W-1:0]   frc_wdata,
    output logic [FRC_W-1:0]   frc_eff,
    output frc_state_e         state
);
    frc_state_e        state_q, state_d;
    logic [FRC_W-1:0]  shadow_q, active_q;
    logic              at_point, load_now;

    always_comb begin
        unique case (reload_sel)
            RLD_ZERO:   at_point = ev.zero;
            RLD_PERIOD: at_point = ev.period;
            RLD_EITHER: at_point = ev.zero | ev.period;
            RLD_NOW:    at_point = 1'b1;
            default:    at_point = 1'b0;
        endcase
    end

    assign load_now = (state_q == FRC_PENDING) && tick && at_point;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FRC_SYNCED:  if (frc_wr) state_d = FRC_PENDING;
            FRC_PENDING: if (load_now && !frc_wr) state_d = FRC_SYNCED;
            default:     state_d = FRC_SYNCED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= FRC_SYNCED;
            shadow_q <= '0;
            active_q <= '0;
        end else begin
            state_q <= state_d;
            if (load_now) active_q <= shadow_q;
            if (frc_wr)   shadow_q <= frc_wdata;
        end
    end

    assign frc_eff = load_now ? shadow_q : active_q;
    assign state   = state_q;
endmodule

// File: rtl/aq_chan.sv
module aq_chan
    import aq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  evt_t               ev,
    input  act_word_t          act,
    input  logic [CODE_W-1:0]  frc,
    output logic               level
);
    lvl_e lvl_q, lvl_d;
    act_e win;

    always_comb begin
        if (ev.cmpb && act.on_cmpb != ACT_NONE)           win = act.on_cmpb;
        else if (ev.cmpa && act.on_cmpa != ACT_NONE)      win = act.on_cmpa;
        else if (ev.period && act.on_period != ACT_NONE)  win = act.on_period;
        else if (ev.zero && act.on_zero != ACT_NONE)      win = act.on_zero;
        else                                              win = ACT_NONE;
    end

    always_comb begin
        lvl_d = lvl_q;
        if (tick) begin
            if (frc == 2'b01)      lvl_d = LVL_LOW;
            else if (frc == 2'b10) lvl_d = LVL_HIGH;
            else begin
                unique case (win)
                    ACT_NONE:   lvl_d = lvl_q;
                    ACT_LOW:    lvl_d = LVL_LOW;
                    ACT_HIGH:   lvl_d = LVL_HIGH;
                    ACT_TOGGLE: lvl_d = (lvl_q == LVL_HIGH) ? LVL_LOW : LVL_HIGH;
                    default:    lvl_d = lvl_q;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= LVL_LOW;
        else        lvl_q <= lvl_d;
    end

    assign level = (lvl_q == LVL_HIGH);
endmodule

// File: rtl/pwm_aq.sv
module pwm_aq
    import aq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               ev_zero,
    input  logic               ev_period,
    input  logic               ev_cmpa,
    input  logic               ev_cmpb,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [9:0]         wr_data,
    output logic               pwm_a,
    output logic               pwm_b
);
    evt_t              ev;
    act_word_t         act_q [NUM_CH];
    rld_e              reload_sel;
    logic              frc_wr;
    logic [FRC_W-1:0]  frc_wdata;
    logic [FRC_W-1:0]  frc_eff;
    frc_state_e        frc_state;
    logic [NUM_CH-1:0] lvl;

    assign ev = '{zero: ev_zero, period: ev_period, cmpa: ev_cmpa, cmpb: ev_cmpb};

    aq_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .act_q(act_q), .reload_sel(reload_sel),
        .frc_wr(frc_wr), .frc_wdata(frc_wdata)
    );

    aq_force_ctl u_force (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ev(ev),
        .reload_sel(reload_sel), .frc_wr(frc_wr), .frc_wdata(frc_wdata),
        .frc_eff(frc_eff), .state(frc_state)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            aq_chan u_chan (
                .clk(clk), .rst_n(rst_n), .tick(tick), .ev(ev),
                .act(act_q[c]), .frc(frc_eff[c*CODE_W +: CODE_W]),
                .level(lvl[c])
            );
        end
    endgenerate

    assign pwm_a = lvl[0];
    assign pwm_b = lvl[1];
endmodule

// File: rtl/pwm_aq_chk.sv
module pwm_aq_chk
    import aq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              wr_en,
    input logic [1:0]        wr_addr,
    input logic              pwm_a,
    input logic              pwm_b,
    input logic [FRC_W-1:0]  frc_eff,
    input frc_state_e        frc_state,
    input rld_e              reload_sel
);
    // R1: reset drives both outputs low
    a_r1_reset_low: assert property (@(posedge clk)
        !rst_n |=> (!pwm_a && !pwm_b));

    // R3: no tick, no output change
    a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(pwm_a) && $stable(pwm_b)));

    // R5: force high on A wins on a tick
    a_r5_force_high_a: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && frc_eff[1:0] == 2'b10) |=> pwm_a);

    // R5: force low on B wins on a tick
    a_r5_force_low_b: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && frc_eff[3:2] == 2'b01) |=> !pwm_b);

    // R6: a pending value waits while no tick arrives
    a_r6_pending_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (frc_state == FRC_PENDING && !tick) |=> (frc_state == FRC_PENDING));

    // R9: immediate reload finishes on the next tick
    a_r9_immediate_load: assert property (@(posedge clk) disable iff (!rst_n)
        (frc_state == FRC_PENDING && tick && reload_sel == RLD_NOW &&
         !(wr_en && wr_addr == 2'd3)) |=> (frc_state == FRC_SYNCED));
endmodule

bind pwm_aq pwm_aq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .pwm_a(pwm_a), .pwm_b(pwm_b), .frc_eff(frc_eff),
    .frc_state(frc_state), .reload_sel(reload_sel)
);

// File: tb/pwm_aq_test.sv
module pwm_aq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       ev_zero = 1'b0, ev_period = 1'b0, ev_cmpa = 1'b0, ev_cmpb = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [9:0] wr_data = '0;
    logic       pwm_a, pwm_b;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    pwm_aq uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ev_zero(ev_zero),
        .ev_period(ev_period), .ev_cmpa(ev_cmpa), .ev_cmpb(ev_cmpb),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    typedef struct {
        bit    a;
        bit    b;
        string req;
    } exp_t;
    exp_t sb[$];

    // reference state built from the requirements
    bit [9:0] m_act [2];
    bit [1:0] m_rsel;
    bit [3:0] m_sh, m_ac;
    bit       m_pend;
    bit       m_out [2];

    function automatic bit apply(bit cur, bit [9:0] w, bit [1:0] f,
                                 bit z, bit p, bit ca, bit cb);
        bit [1:0] code;
        if (f == 2'b01) return 1'b0;
        if (f == 2'b10) return 1'b1;
        code = 2'b00;
        if (cb && w[9:8] != 0)      code = w[9:8];
        else if (ca && w[5:4] != 0) code = w[5:4];
        else if (p && w[3:2] != 0)  code = w[3:2];
        else if (z && w[1:0] != 0)  code = w[1:0];
        case (code)
            2'b01:   return 1'b0;
            2'b10:   return 1'b1;
            2'b11:   return ~cur;
            default: return cur;
        endcase
    endfunction

    task automatic cyc(bit w, bit [1:0] a, bit [9:0] d, bit t,
                       bit z, bit p, bit ca, bit cb, string req);
        bit       pt, ld;
        bit [3:0] eff;
        exp_t     e;
        @(negedge clk);
        wr_en = w; wr_addr = a; wr_data = d; tick = t;
        ev_zero = z; ev_period = p; ev_cmpa = ca; ev_cmpb = cb;
        case (m_rsel)
            2'b00:   pt = z;
            2'b01:   pt = p;
            2'b10:   pt = z | p;
            default: pt = 1'b1;
        endcase
        ld  = m_pend && t && pt;
        eff = ld ? m_sh : m_ac;
        if (t) begin
            m_out[0] = apply(m_out[0], m_act[0], eff[1:0], z, p, ca, cb);
            m_out[1] = apply(m_out[1], m_act[1], eff[3:2], z, p, ca, cb);
        end
        if (ld) begin m_ac = m_sh; m_pend = 1'b0; end
        if (w) begin
            case (a)
                2'd0: m_act[0] = d;
                2'd1: m_act[1] = d;
                2'd2: m_rsel = d[7:6];
                default: begin m_sh = d[3:0]; m_pend = 1'b1; end
            endcase
        end
        @(posedge clk);
        #1;
        e.a = m_out[0]; e.b = m_out[1]; e.req = req;
        sb.push_back(e);
    endtask

    task automatic wr(bit [1:0] a, bit [9:0] d, string req);
        cyc(1'b1, a, d, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, req);
    endtask

    task automatic tk(bit z, bit p, bit ca, bit cb, string req);
        cyc(1'b0, 2'd0, 10'd0, 1'b1, z, p, ca, cb, req);
    endtask

    // monitor: compare one edge after each stimulus
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_checks++;
            if (pwm_a !== e.a || pwm_b !== e.b) begin
                n_fail++;
                $display("FAIL %s: a/b actual %b%b expected %b%b",
                         e.req, pwm_a, pwm_b, e.a, e.b);
            end
        end
    end

    initial begin
        #4000000;
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        m_act[0] = '0; m_act[1] = '0; m_rsel = '0; m_sh = '0; m_ac = '0;
        m_pend = 0; m_out[0] = 0; m_out[1] = 0;
        repeat (3) @(posedge clk);
        #1;
        n_checks++;
        if (pwm_a !== 1'b0 || pwm_b !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: reset a/b actual %b%b expected 00", pwm_a, pwm_b);
        end
        @(negedge clk); rst_n = 1'b1;

        // R1: zeroed action words, events do nothing
        tk(1, 1, 1, 1, "R1");
        tk(1, 0, 0, 0, "R1");

        // R2: field positions and codes on A
        wr(2'd0, 10'b00_00_00_00_10, "R2");
        tk(1, 0, 0, 0, "R2");
        wr(2'd0, 10'b00_00_00_01_00, "R2");
        tk(0, 1, 0, 0, "R2");
        wr(2'd0, 10'b00_00_11_00_00, "R2");
        tk(0, 0, 1, 0, "R2");
        tk(0, 0, 1, 0, "R2");
        wr(2'd0, 10'b10_00_00_00_00, "R2");
        tk(0, 0, 0, 1, "R2");

        // R3: events without tick are ignored
        wr(2'd0, 10'b00_00_00_00_01, "R3");
        cyc(0, 0, 0, 0, 1, 1, 1, 1, "R3");
        cyc(0, 0, 0, 0, 1, 0, 0, 0, "R3");
        tk(1, 0, 0, 0, "R3");

        // R4: priority cmpb > cmpa > period > zero, 00 transparent
        wr(2'd0, 10'b01_00_10_01_10, "R4");
        tk(1, 1, 1, 1, "R4");
        tk(1, 1, 1, 0, "R4");
        tk(1, 1, 0, 0, "R4");
        tk(1, 0, 0, 0, "R4");
        wr(2'd0, 10'b00_00_00_00_01, "R4");
        tk(1, 1, 1, 1, "R4");

        // R10 / R11: polarity waveforms, channels independent
        wr(2'd0, 10'h01A, "R10");
        wr(2'd1, 10'h205, "R10");
        for (int k = 0; k < 2; k++) begin
            tk(1, 0, 0, 0, "R10");
            tk(0, 0, 1, 0, "R10");
            tk(0, 0, 0, 1, "R11");
            tk(0, 1, 0, 0, "R10");
        end
        wr(2'd1, 10'h10A, "R10");
        tk(1, 0, 0, 0, "R10");
        tk(0, 0, 0, 1, "R11");

        // R9 / R5: immediate force
        wr(2'd2, 10'b11_000000, "R9");
        wr(2'd3, 10'b0110, "R9");
        cyc(0, 0, 0, 0, 1, 1, 0, 0, "R9");
        tk(0, 0, 0, 0, "R9");
        tk(1, 1, 1, 1, "R5");
        wr(2'd3, 10'b1001, "R5");
        tk(0, 0, 1, 0, "R5");
        tk(1, 0, 0, 1, "R5");
        cyc(1, 2'd3, 10'b0000, 1, 0, 0, 1, 0, "R9");
        tk(0, 0, 1, 0, "R9");
        tk(1, 0, 0, 0, "R9");
        wr(2'd3, 10'b1100, "R5");
        tk(0, 0, 0, 0, "R5");
        tk(0, 0, 1, 1, "R5");

        // R6: reload at zero
        wr(2'd2, 10'b00_000000, "R6");
        wr(2'd3, 10'b1010, "R6");
        tk(0, 1, 1, 0, "R6");
        tk(0, 0, 0, 1, "R6");
        tk(1, 0, 1, 1, "R6");
        tk(0, 0, 1, 1, "R6");

        // R7: reload at period
        wr(2'd2, 10'b01_000000, "R7");
        wr(2'd3, 10'b0101, "R7");
        tk(1, 0, 0, 0, "R7");
        tk(0, 1, 0, 0, "R7");
        tk(1, 0, 0, 0, "R7");

        // R8: reload at zero or period
        wr(2'd2, 10'b10_000000, "R8");
        wr(2'd3, 10'b0000, "R8");
        tk(0, 0, 1, 1, "R8");
        tk(0, 1, 0, 0, "R8");
        wr(2'd3, 10'b0110, "R8");
        tk(0, 0, 1, 0, "R8");
        tk(1, 0, 0, 0, "R8");
        tk(0, 1, 1, 1, "R8");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule